// File: doc/BRIEF.md
# Write-Once-Memory 2-bit Codec

This block lets a 3-bit storage cell hold a 2-bit value twice between erases. A first write into an erased cell uses a light code with at most one bit set. A later change of value uses the bitwise complement of the new value's light code, which has two or three bits set. Both codes only ever turn 0 bits into 1, so the cell never needs a bit cleared until the next erase. A third change, or any write whose code would have to clear a stored 1, cannot be done in place. The block then raises an erase request and marks the location as erased in its own bookkeeping. The physical erase is left to a separate policy.

For each location the block keeps a generation: erased, written once or written twice. A write request supplies an address, a 2-bit value and the code that the cell currently holds. One cycle later the block answers with exactly one of three results. It may give a code to program, it may ask for an erase, or it may do nothing because the value is already stored. The decoded value of the supplied stored code is also presented combinationally, with no write needed.

Top module: `wom_codec`

## Requirements
- R1: The light (first-generation) codes are: value 00 to 000, 01 to 001, 10 to 010 and 11 to 100.
- R2: The heavy (second-generation) codes are the complements of the light codes: 00 to 111, 01 to 110, 10 to 101 and 11 to 011.
- R3: `rd_data` decodes `cur_code` combinationally. A code with zero or one bit set is read through the light table. A code with two or three bits set is read through the heavy table. `rd_second` is 1 exactly when two or more bits are set.
- R4: A write to an erased location programs the light code of the written value. The location then counts as written once.
- R5: A write of a different value to a location written once programs the heavy code of that value. The location then counts as written twice.
- R6: A write to a non-erased location whose value equals the decoded stored value leaves `prog_en` and `erase_need` low. The generation of the location is unchanged.
- R7: A write of a different value to a location written twice raises `erase_need` and does not program.
- R8: Every programmed code has a 1 in each bit position where `cur_code` has a 1. A write whose code would break this raises `erase_need` instead of programming.
- R9: A write that raises `erase_need` marks its location as erased. The next write to that location is treated as a first write.
- R10: Results are registered and appear in the cycle after `wr_en`. They last one cycle and are mutually exclusive. Both flags are low after a cycle without `wr_en`.
- R11: A synchronous reset clears both result flags and returns every location to the erased generation, even while `wr_en` is high.
- R12: Locations are independent. A write changes only the generation of the location it addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request strobe |
| wr_addr | input | LOC_AW | Location of the write |
| wr_data | input | 2 | Value to store |
| cur_code | input | 3 | Code currently held by the addressed cell |
| rd_data | output | 2 | Value decoded from `cur_code` |
| rd_second | output | 1 | `cur_code` is a heavy code |
| prog_en | output | 1 | Program `prog_code` into the cell |
| prog_code | output | 3 | Code to program |
| erase_need | output | 1 | Write cannot be done in place; location marked erased |

## Verification
Two functions share one cycle here: decoding the supplied stored code and judging a write against it. The same-value test of R6 is built directly on the decode. The bench provokes this by presenting, with the write request, a stored code whose decoded value equals the written value, first in the light generation and then in the heavy one. It then checks the outcome one cycle later: no program and no erase. A follow-up write shows that the generation did not move. The bench also feeds stored codes that disagree with the tracked generation. In that case the decode and the covering test must together turn the write into an erase request.

// File: rtl/wom_pkg.sv
package wom_pkg;

    localparam int DATA_W = 2;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        LOC_ERASED = 2'd0,
        LOC_ONCE   = 2'd1,
        LOC_TWICE  = 2'd2
    } loc_gen_e;

    typedef struct packed {
        logic              prog;
        logic              erase;
        logic [CODE_W-1:0] code;
    } wr_result_t;

    // Light code for a value (at most one bit set)
    function automatic logic [CODE_W-1:0] light_code(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] c;
        case (d)
            2'b00:   c = 3'b000;
            2'b01:   c = 3'b001;
            2'b10:   c = 3'b010;
            default: c = 3'b100;
        endcase
        return c;
    endfunction

    // Heavy code: complement of the light code
    function automatic logic [CODE_W-1:0] heavy_code(input logic [DATA_W-1:0] d);
        return ~light_code(d);
    endfunction

    function automatic logic code_is_heavy(input logic [CODE_W-1:0] c);
        return ($countones(c) >= 2);
    endfunction

    function automatic logic [DATA_W-1:0] code_value(input logic [CODE_W-1:0] c);
        logic [CODE_W-1:0] base;
        logic [DATA_W-1:0] d;
        base = code_is_heavy(c) ? ~c : c;
        case (base)
            3'b001:  d = 2'b01;
            3'b010:  d = 2'b10;
            3'b100:  d = 2'b11;
            default: d = 2'b00;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/wom_decode.sv
module wom_decode
    import wom_pkg::*;
(
    input  logic [CODE_W-1:0] code_in,
    output logic [DATA_W-1:0] value_out,
    output logic              heavy_out
);

    always_comb begin
        heavy_out = code_is_heavy(code_in);
        value_out = code_value(code_in);
    end

endmodule

// File: rtl/wom_gen_table.sv
module wom_gen_table
    import wom_pkg::*;
#(
    parameter int LOC_AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LOC_AW-1:0] rd_addr,
    output loc_gen_e          rd_gen,
    input  logic              upd_en,
    input  logic [LOC_AW-1:0] upd_addr,
    input  loc_gen_e          upd_gen
);

    localparam int NUM_LOC = 1 << LOC_AW;

    loc_gen_e gen_vec [NUM_LOC];

    for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
        loc_gen_e gen_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                gen_q <= LOC_ERASED;
            end else if (upd_en && (upd_addr == LOC_AW'(i))) begin
                gen_q <= upd_gen;
            end
        end
        assign gen_vec[i] = gen_q;
    end

    assign rd_gen = gen_vec[rd_addr];

endmodule

// File: rtl/wom_write_ctrl.sv
module wom_write_ctrl
    import wom_pkg::*;
(
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CODE_W-1:0] cur_code,
    input  logic [DATA_W-1:0] stored_value,
    input  loc_gen_e          gen,
    output wr_result_t        result,
    output logic              upd_en,
    output loc_gen_e          upd_gen
);

    logic [CODE_W-1:0] target;
    logic              covers;
    logic              same_value;

    always_comb begin
        target     = (gen == LOC_ERASED) ? light_code(wr_data) : heavy_code(wr_data);
        covers     = ((cur_code & ~target) == '0);
        same_value = (gen != LOC_ERASED) && (wr_data == stored_value);

        result  = '0;
        upd_en  = 1'b0;
        upd_gen = gen;

        if (wr_en && !same_value) begin
            if ((gen == LOC_TWICE) || !covers) begin
                result.erase = 1'b1;
                upd_en       = 1'b1;
                upd_gen      = LOC_ERASED;
            end else begin
                result.prog = 1'b1;
                result.code = target;
                upd_en      = 1'b1;
                upd_gen     = (gen == LOC_ERASED) ? LOC_ONCE : LOC_TWICE;
            end
        end
    end

endmodule

// File: rtl/wom_codec.sv
module wom_codec
    import wom_pkg::*;
#(
    parameter int LOC_AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LOC_AW-1:0] wr_addr,
    input  logic [1:0]        wr_data,
    input  logic [2:0]        cur_code,
    output logic [1:0]        rd_data,
    output logic              rd_second,
    output logic              prog_en,
    output logic [2:0]        prog_code,
    output logic              erase_need
);

    loc_gen_e   sel_gen;
    loc_gen_e   upd_gen;
    logic       upd_en;
    wr_result_t res_d;
    wr_result_t res_q;

    wom_decode u_decode (
        .code_in   (cur_code),
        .value_out (rd_data),
        .heavy_out (rd_second)
    );

    wom_gen_table #(.LOC_AW(LOC_AW)) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_addr  (wr_addr),
        .rd_gen   (sel_gen),
        .upd_en   (upd_en),
        .upd_addr (wr_addr),
        .upd_gen  (upd_gen)
    );

    wom_write_ctrl u_ctrl (
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .cur_code     (cur_code),
        .stored_value (rd_data),
        .gen          (sel_gen),
        .result       (res_d),
        .upd_en       (upd_en),
        .upd_gen      (upd_gen)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign prog_en    = res_q.prog;
    assign erase_need = res_q.erase;
    assign prog_code  = res_q.code;

endmodule

// File: rtl/wom_codec_chk.sv
module wom_codec_chk
    import wom_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [1:0] wr_data,
    input logic [2:0] cur_code,
    input logic [1:0] rd_data,
    input loc_gen_e   sel_gen,
    input logic       prog_en,
    input logic [2:0] prog_code,
    input logic       erase_need
);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (!prog_en && !erase_need));

    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        !(prog_en && erase_need));

    // R8
    cover_bits_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (!prog_en || ((prog_code & $past(cur_code)) == $past(cur_code))));

    // R6
    same_value_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (sel_gen != LOC_ERASED) && (wr_data == rd_data))
        |=> (!prog_en && !erase_need));

    // R7
    second_gen_full_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (sel_gen == LOC_TWICE) && (wr_data != rd_data)) |=> erase_need);

    // R4
    first_write_light_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (sel_gen == LOC_ERASED) && (cur_code == 3'b000))
        |=> (prog_en && ($countones(prog_code) <= 1)));

    // R5
    second_write_heavy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (sel_gen == LOC_ONCE) && (wr_data != rd_data) && ($countones(cur_code) <= 1))
        |=> (prog_en && ($countones(prog_code) >= 2)));

endmodule

bind wom_codec wom_codec_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .cur_code   (cur_code),
    .rd_data    (rd_data),
    .sel_gen    (sel_gen),
    .prog_en    (prog_en),
    .prog_code  (prog_code),
    .erase_need (erase_need)
);

// File: tb/sim_wom_codec.sv
`timescale 1ns/1ps
module sim_wom_codec;

    localparam int LOC_AW = 4;
    localparam int NVEC   = 18;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [LOC_AW-1:0] wr_addr = '0;
    logic [1:0]        wr_data = '0;
    logic [2:0]        cur_code = '0;
    logic [1:0]        rd_data;
    logic              rd_second;
    logic              prog_en;
    logic [2:0]        prog_code;
    logic              erase_need;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wom_codec #(.LOC_AW(LOC_AW)) u0 (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cur_code   (cur_code),
        .rd_data    (rd_data),
        .rd_second  (rd_second),
        .prog_en    (prog_en),
        .prog_code  (prog_code),
        .erase_need (erase_need)
    );

    // Fields: addr[13:10] data[9:8] cur[7:5] prog[4] erase[3] code[2:0]
    localparam logic [13:0] VEC [NVEC] = '{
        {4'd0, 2'b10, 3'b000, 1'b1, 1'b0, 3'b010},  // 0  R4 first write
        {4'd0, 2'b10, 3'b010, 1'b0, 1'b0, 3'b000},  // 1  R6 same, light gen
        {4'd0, 2'b01, 3'b010, 1'b1, 1'b0, 3'b110},  // 2  R5 second write
        {4'd0, 2'b01, 3'b110, 1'b0, 1'b0, 3'b000},  // 3  R6 same, heavy gen
        {4'd0, 2'b11, 3'b110, 1'b0, 1'b1, 3'b000},  // 4  R7 third change
        {4'd0, 2'b11, 3'b110, 1'b0, 1'b1, 3'b000},  // 5  R9 marked erased, cell not cleared
        {4'd0, 2'b11, 3'b000, 1'b1, 1'b0, 3'b100},  // 6  R9 first write after erase
        {4'd1, 2'b00, 3'b000, 1'b1, 1'b0, 3'b000},  // 7  R1 value 00
        {4'd1, 2'b11, 3'b000, 1'b1, 1'b0, 3'b011},  // 8  R2 heavy of 11
        {4'd2, 2'b01, 3'b000, 1'b1, 1'b0, 3'b001},  // 9  R1 value 01
        {4'd2, 2'b00, 3'b001, 1'b1, 1'b0, 3'b111},  // 10 R2 heavy of 00
        {4'd3, 2'b11, 3'b011, 1'b0, 1'b1, 3'b000},  // 11 R8 erased loc, dirty cell
        {4'd3, 2'b00, 3'b000, 1'b1, 1'b0, 3'b000},  // 12 R9 still erased
        {4'd4, 2'b01, 3'b000, 1'b1, 1'b0, 3'b001},  // 13 R4
        {4'd4, 2'b10, 3'b011, 1'b0, 1'b1, 3'b000},  // 14 R8 heavy code cannot cover
        {4'd5, 2'b11, 3'b000, 1'b1, 1'b0, 3'b100},  // 15 R1 value 11
        {4'd5, 2'b10, 3'b100, 1'b1, 1'b0, 3'b101},  // 16 R2 heavy of 10
        {4'd0, 2'b11, 3'b100, 1'b0, 1'b0, 3'b000}   // 17 R12 loc 0 kept its state
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 13:      return "R4";
            1, 3:       return "R6";
            2:          return "R5";
            4:          return "R7";
            5, 6, 12:   return "R9";
            7, 9, 15:   return "R1";
            8, 10, 16:  return "R2";
            11, 14:     return "R8";
            default:    return "R12";
        endcase
    endfunction

    // R3 expected decode, from the two code tables
    function automatic logic [2:0] exp_decode(input logic [2:0] c);
        case (c)
            3'b000: return {1'b0, 2'b00};
            3'b001: return {1'b0, 2'b01};
            3'b010: return {1'b0, 2'b10};
            3'b100: return {1'b0, 2'b11};
            3'b111: return {1'b1, 2'b00};
            3'b110: return {1'b1, 2'b01};
            3'b101: return {1'b1, 2'b10};
            default: return {1'b1, 2'b11};
        endcase
    endfunction

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got prog=%b erase=%b code=%b, expected prog=%b erase=%b code=%b",
                     tag, act[4], act[3], act[2:0], exp[4], exp[3], exp[2:0]);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [1:0] d, input logic [2:0] c,
                            input logic [4:0] exp, input string tag);
        @(negedge clk);
        wr_en    = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        cur_code = c;
        @(negedge clk);
        wr_en = 1'b0;
        check(tag, {prog_en, erase_need, prog_code}, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", {prog_en, erase_need, prog_code}, 5'b0);
        rst = 1'b0;

        // R10 no request, no result
        @(negedge clk);
        @(negedge clk);
        check("R10", {prog_en, erase_need, prog_code}, 5'b0);

        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i][13:10], VEC[i][9:8], VEC[i][7:5], VEC[i][4:0], vec_tag(i));
        end

        // R10 result lasts one cycle only
        @(negedge clk);
        check("R10", {prog_en, erase_need, prog_code}, 5'b0);

        // R3 combinational decode of all stored codes
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            cur_code = 3'(c);
            #1;
            checks++;
            if ({rd_second, rd_data} !== exp_decode(3'(c))) begin
                errors++;
                $display("FAIL R3: code=%b got second=%b value=%b, expected second=%b value=%b",
                         3'(c), rd_second, rd_data, exp_decode(3'(c))[2], exp_decode(3'(c))[1:0]);
            end
        end

        // R11 reset during a write request
        @(negedge clk);
        rst      = 1'b1;
        wr_en    = 1'b1;
        wr_addr  = 4'd0;
        wr_data  = 2'b00;
        cur_code = 3'b000;
        @(negedge clk);
        wr_en = 1'b0;
        check("R11", {prog_en, erase_need, prog_code}, 5'b0);
        rst = 1'b0;
        // location 0 was written once; after reset it must act erased
        do_write(4'd0, 2'b01, 3'b000, {1'b1, 1'b0, 3'b001}, "R11");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no completion, expected completion within limit");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule